// File: doc/BRIEF.md
# Software-Loaded Address Translation Buffer

This block holds two small, fully associative translation buffers: one for data accesses and one for instruction fetches. No hardware page walker feeds it. Privileged software loads each entry with two register writes. One write stages half of the entry, and the following write of the other half commits it. On the data side the page-table word is staged first and the virtual tag write commits. On the instruction side the tag is staged first and the page-table word write commits. Each committed entry also records the current address-space number of its side.

Software can invalidate every entry of a side, only the per-process entries (those whose global bit is clear), or the single entry that matches a virtual address in the current address space. A combinational lookup port returns the physical frame and permission bits for a virtual address on the selected side. A registered read-back port gives the packed page-table word of the entry found by the most recent lookup. Pages are 8 KB, so the virtual page number is address bits 42:13.

Top module: `swtlb_top`

## Requirements
- R1: A write is decoded from `wr_sel`. Bit 3 selects the side (0 data, 1 instruction) and bits 2:0 select the operation: 0 set the address-space number from `wr_data[6:0]`, 1 stage, 2 commit, 3 invalidate all, 4 invalidate non-global, 5 invalidate single. Operation codes 6 and 7 change nothing.
- R2: On the data side, operation 1 stages a page-table word and operation 2 commits. The commit takes its tag from `wr_data` and writes an entry built from the staged word plus the data-side address-space number. The word layout is: frame at bits 58:32, read enables at 11:8, write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4, granularity hint at 6:5.
- R3: On the instruction side, operation 1 stages the tag and operation 2 commits. The commit takes the page-table word from `wr_data`, stores the instruction-side address-space number, and forces the write enables to zero.
- R4: A commit is rejected if no half is staged or if the granularity hint is nonzero. A rejected commit writes no entry and raises `commit_err` for exactly the following cycle. An accepted commit consumes the staged half. A rejected commit leaves the staged half in place.
- R5: A lookup hits when a valid entry's page number (bits 42:13) matches and either the entry is global or its address-space number equals the side's current one. If several entries match, the lowest-numbered entry wins. While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high.
- R6: On a miss, or when `lk_valid` is low, the frame, enable and fault outputs are zero.
- R7: Each side has 16 entries, filled round-robin from entry 0. The fill pointer advances only on an accepted commit.
- R8: Invalidate-all clears every entry of its side.
- R9: Invalidate non-global clears only the entries of its side whose global bit is clear.
- R10: Invalidate single clears the entries whose page number matches the address in `wr_data` and that are global or tagged with the current address-space number.
- R11: Each lookup loads `rb_pte` on the next edge with the hit entry packed in the R2 layout, plus the 7-bit address-space number ORed in at bit 57. A miss loads zero. The register holds its value when there is no lookup.
- R12: Writes and lookups on one side never affect the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Side and operation of the write |
| wr_data | input | 64 | Write value |
| lk_valid | input | 1 | Lookup request |
| lk_side | input | 1 | Lookup side, 0 data, 1 instruction |
| lk_va | input | 64 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_pfn | output | 27 | Physical frame on hit |
| lk_re | output | 4 | Read enables on hit |
| lk_we | output | 4 | Write enables on hit |
| lk_for | output | 1 | Fault-on-read on hit |
| lk_fow | output | 1 | Fault-on-write on hit |
| rb_pte | output | 64 | Packed word of the last lookup |
| commit_err | output | 1 | Rejected-commit pulse |

Each side's staging controller has two states: `ST_EMPTY` and `ST_HELD`. A stage write moves it from `ST_EMPTY` to `ST_HELD` (STAGE), or overwrites the held half while in `ST_HELD`. An accepted commit returns it from `ST_HELD` to `ST_EMPTY` (ACCEPT). A rejected commit leaves the state unchanged (REJECT).

## Verification
The hardest case to reach from the ports is the overwrite of a live entry by round-robin fill. It needs more accepted commits than the buffer has entries, counted from a pointer that rejected commits must not have moved. The stimulus first mixes rejected and accepted commits. It then issues sixteen more accepted commits and probes an entry just before and just after its slot is reused. Invalidate-single is steered with the address-space number set so that a same-page entry from another address space must survive, and a global entry must not.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

    localparam int WORD_W  = 64;
    localparam int PFN_W   = 27;
    localparam int PFN_LO  = 32;
    localparam int PERM_W  = 4;
    localparam int RE_LO   = 8;
    localparam int WE_LO   = 12;
    localparam int FR_BIT  = 1;
    localparam int FW_BIT  = 2;
    localparam int GBL_BIT = 4;
    localparam int GH_LO   = 5;
    localparam int GH_W    = 2;
    localparam int ASN_W   = 7;
    localparam int ASN_LO  = 57;
    localparam int VPN_LO  = 13;
    localparam int VPN_HI  = 42;
    localparam int VPN_W   = VPN_HI - VPN_LO + 1;

    typedef enum logic [2:0] {
        OP_ASN      = 3'd0,
        OP_STAGE    = 3'd1,
        OP_COMMIT   = 3'd2,
        OP_INV_ALL  = 3'd3,
        OP_INV_PROC = 3'd4,
        OP_INV_ONE  = 3'd5
    } tlb_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } stage_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] re;
        logic [PERM_W-1:0] we;
        logic              fr;
        logic              fw;
        logic              gbl;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [WORD_W-1:0] w, input logic kill_we);
        pte_t p;
        p.pfn = w[PFN_LO +: PFN_W];
        p.re  = w[RE_LO +: PERM_W];
        p.we  = kill_we ? '0 : w[WE_LO +: PERM_W];
        p.fr  = w[FR_BIT];
        p.fw  = w[FW_BIT];
        p.gbl = w[GBL_BIT];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] pack_pte(input pte_t p, input logic [ASN_W-1:0] asn);
        logic [WORD_W-1:0] w;
        w = '0;
        w = w | (WORD_W'(p.pfn) << PFN_LO);
        w = w | (WORD_W'(p.re) << RE_LO);
        w = w | (WORD_W'(p.we) << WE_LO);
        w = w | (WORD_W'(p.fr) << FR_BIT);
        w = w | (WORD_W'(p.fw) << FW_BIT);
        w = w | (WORD_W'(p.gbl) << GBL_BIT);
        w = w | (WORD_W'(asn) << ASN_LO);
        return w;
    endfunction

endpackage

// File: rtl/swtlb_stager.sv
module swtlb_stager
    import swtlb_pkg::*;
#(
    parameter bit TAG_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_we,
    input  logic              commit_we,
    input  logic [WORD_W-1:0] wr_data,
    output logic              cm_fire,
    output pte_t              cm_pte,
    output logic [VPN_W-1:0]  cm_vpn,
    output logic              cm_err
);

    stage_e            state_q;
    stage_e            state_d;
    logic [WORD_W-1:0] held_q;
    logic [WORD_W-1:0] pte_word;
    logic [WORD_W-1:0] tag_word;
    logic              gh_bad;
    logic              accept;
    logic              reject;
    logic              unused_bits;

    generate
        if (TAG_FIRST) begin : g_tag_first
            assign pte_word = wr_data;
            assign tag_word = held_q;
        end else begin : g_pte_first
            assign pte_word = held_q;
            assign tag_word = wr_data;
        end
    endgenerate

    assign gh_bad  = pte_word[GH_LO +: GH_W] != '0;
    assign accept  = commit_we && (state_q == ST_HELD) && !gh_bad;
    assign reject  = commit_we && !accept;
    assign cm_fire = accept;
    assign cm_pte  = unpack_pte(pte_word, TAG_FIRST);
    assign cm_vpn  = tag_word[VPN_HI:VPN_LO];

    assign unused_bits = ^{pte_word[WORD_W-1:PFN_LO+PFN_W], pte_word[PFN_LO-1:WE_LO+PERM_W],
                           pte_word[GH_LO+GH_W], pte_word[3], pte_word[0],
                           tag_word[WORD_W-1:VPN_HI+1], tag_word[VPN_LO-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: STAGE, ACCEPT, REJECT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (stage_we) begin
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (accept) begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs and staged half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            cm_err <= 1'b0;
        end else begin
            cm_err <= reject;
            if (stage_we) begin
                held_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/swtlb_array.sv
module swtlb_array
    import swtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             asn_we,
    input  logic [ASN_W-1:0] asn_in,
    input  logic             cm_fire,
    input  pte_t             cm_pte,
    input  logic [VPN_W-1:0] cm_vpn,
    input  logic             inv_all,
    input  logic             inv_proc,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output pte_t             lk_pte,
    output logic [ASN_W-1:0] lk_asn
);

    logic [ASN_W-1:0] asn_q;
    logic [IDX_W-1:0] rr_q;
    logic             ent_v   [ENTRIES];
    logic [VPN_W-1:0] ent_vpn [ENTRIES];
    pte_t             ent_pte [ENTRIES];
    logic [ASN_W-1:0] ent_asn [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] inv_match;
    logic [IDX_W-1:0] sel;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            logic space_ok;
            assign space_ok     = ent_pte[g].gbl || (ent_asn[g] == asn_q);
            assign lk_match[g]  = ent_v[g] && space_ok && (ent_vpn[g] == lk_vpn);
            assign inv_match[g] = ent_v[g] && space_ok && (ent_vpn[g] == inv_vpn);
        end
    endgenerate

    // lowest-numbered match wins
    always_comb begin
        lk_hit = 1'b0;
        sel    = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) begin
                lk_hit = 1'b1;
                sel    = IDX_W'(i);
            end
        end
    end

    assign lk_pte = ent_pte[sel];
    assign lk_asn = ent_asn[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asn_q <= '0;
            rr_q  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_v[i]   <= 1'b0;
                ent_vpn[i] <= '0;
                ent_pte[i] <= '0;
                ent_asn[i] <= '0;
            end
        end else begin
            if (asn_we) begin
                asn_q <= asn_in;
            end
            if (cm_fire) begin
                ent_v[rr_q]   <= 1'b1;
                ent_vpn[rr_q] <= cm_vpn;
                ent_pte[rr_q] <= cm_pte;
                ent_asn[rr_q] <= asn_q;
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_all || (inv_proc && !ent_pte[i].gbl) || (inv_one && inv_match[i])) begin
                    ent_v[i] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
    import swtlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lk_valid,
    input  logic              lk_side,
    input  logic [WORD_W-1:0] lk_va,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_re,
    output logic [PERM_W-1:0] lk_we,
    output logic              lk_for,
    output logic              lk_fow,
    output logic [WORD_W-1:0] rb_pte,
    output logic              commit_err
);

    localparam int SIDES = 2;

    tlb_op_e          op;
    logic [VPN_W-1:0] lk_vpn;
    logic [SIDES-1:0] side_hit;
    logic [SIDES-1:0] side_err;
    pte_t             side_pte [SIDES];
    logic [ASN_W-1:0] side_asn [SIDES];
    pte_t             sel_pte;
    logic             sel_hit;
    logic             unused_va;

    assign op        = tlb_op_e'(wr_sel[2:0]);
    assign lk_vpn    = lk_va[VPN_HI:VPN_LO];
    assign unused_va = ^{lk_va[WORD_W-1:VPN_HI+1], lk_va[VPN_LO-1:0]};

    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_side
            logic             mine;
            logic             cm_fire;
            pte_t             cm_pte;
            logic [VPN_W-1:0] cm_vpn;

            assign mine = wr_en && (wr_sel[3] == s[0]);

            swtlb_stager #(
                .TAG_FIRST (s == 1)
            ) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .stage_we  (mine && (op == OP_STAGE)),
                .commit_we (mine && (op == OP_COMMIT)),
                .wr_data   (wr_data),
                .cm_fire   (cm_fire),
                .cm_pte    (cm_pte),
                .cm_vpn    (cm_vpn),
                .cm_err    (side_err[s])
            );

            swtlb_array #(
                .ENTRIES (ENTRIES)
            ) u_array (
                .clk      (clk),
                .rst_n    (rst_n),
                .asn_we   (mine && (op == OP_ASN)),
                .asn_in   (wr_data[ASN_W-1:0]),
                .cm_fire  (cm_fire),
                .cm_pte   (cm_pte),
                .cm_vpn   (cm_vpn),
                .inv_all  (mine && (op == OP_INV_ALL)),
                .inv_proc (mine && (op == OP_INV_PROC)),
                .inv_one  (mine && (op == OP_INV_ONE)),
                .inv_vpn  (wr_data[VPN_HI:VPN_LO]),
                .lk_vpn   (lk_vpn),
                .lk_hit   (side_hit[s]),
                .lk_pte   (side_pte[s]),
                .lk_asn   (side_asn[s])
            );
        end
    endgenerate

    assign sel_hit    = side_hit[lk_side];
    assign sel_pte    = (lk_valid && sel_hit) ? side_pte[lk_side] : '0;
    assign lk_hit     = lk_valid && sel_hit;
    assign lk_miss    = lk_valid && !sel_hit;
    assign lk_pfn     = sel_pte.pfn;
    assign lk_re      = sel_pte.re;
    assign lk_we      = sel_pte.we;
    assign lk_for     = sel_pte.fr;
    assign lk_fow     = sel_pte.fw;
    assign commit_err = |side_err;

    // read-back register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_pte <= '0;
        end else if (lk_valid) begin
            rb_pte <= sel_hit ? pack_pte(sel_pte, side_asn[lk_side]) : '0;
        end
    end

endmodule

// File: rtl/swtlb_checks.sv
module swtlb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_sel,
    input logic        lk_valid,
    input logic        lk_side,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic [26:0] lk_pfn,
    input logic [3:0]  lk_re,
    input logic [3:0]  lk_we,
    input logic        lk_for,
    input logic        lk_fow,
    input logic [63:0] rb_pte,
    input logic        commit_err
);

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit ^ lk_miss));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_pfn == '0));

    assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_pfn == '0 && lk_re == '0 && lk_we == '0 && !lk_for && !lk_fow));

    assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_err |-> $past(wr_en && wr_sel[2:0] == 3'd2));

    assert_insn_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_side) |-> (lk_we == '0));

    assert_data_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_side && $past(wr_en && wr_sel == 4'h3)) |-> lk_miss);

    assert_insn_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_side && $past(wr_en && wr_sel == 4'hB)) |-> lk_miss);

    assert_rb_miss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lk_miss) |-> (rb_pte == '0));

    assert_rb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(lk_valid) |-> $stable(rb_pte));

endmodule

bind swtlb_top swtlb_checks u_chk (.*);

// File: tb/test_swtlb_top.sv
module test_swtlb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        lk_valid = 1'b0;
    logic        lk_side = 1'b0;
    logic [63:0] lk_va = '0;
    logic        lk_hit, lk_miss, lk_for, lk_fow, commit_err;
    logic [26:0] lk_pfn;
    logic [3:0]  lk_re, lk_we;
    logic [63:0] rb_pte;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    swtlb_top i_swtlb_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_side(lk_side), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_re(lk_re),
        .lk_we(lk_we), .lk_for(lk_for), .lk_fow(lk_fow), .rb_pte(rb_pte),
        .commit_err(commit_err)
    );

    // behavioural reference state
    localparam logic [63:0] KEEP = 64'h07FF_FFFF_0000_FF16;
    bit          mv   [2][16];
    logic [29:0] mvpn [2][16];
    logic [63:0] mw   [2][16];
    logic [6:0]  masn [2][16];
    logic [6:0]  mcur [2];
    bit          mheld[2];
    logic [63:0] mstage[2];
    int          mrr  [2];
    logic [63:0] exp_rb = '0;
    bit          exp_err = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int mfind(input int s, input logic [63:0] va);
        for (int i = 0; i < 16; i++) begin
            if (mv[s][i] && mvpn[s][i] == va[42:13] && (mw[s][i][4] || masn[s][i] == mcur[s]))
                return i;
        end
        return -1;
    endfunction

    function automatic logic [63:0] mkpte(input int pfn, input int re, input int we,
                                          input int fr, input int fw, input int gbl, input int gh);
        return (64'(pfn) << 32) | (64'(re) << 8) | (64'(we) << 12) | (64'(fr) << 1)
             | (64'(fw) << 2) | (64'(gbl) << 4) | (64'(gh) << 5);
    endfunction

    task automatic compare_model();
        int k;
        logic [38:0] act, exp;
        logic [63:0] w;
        k = lk_valid ? mfind(lk_side, lk_va) : -1;
        w = (k >= 0) ? mw[lk_side][k] : '0;
        exp = {lk_valid && k >= 0, lk_valid && k < 0, w[58:32], w[11:8], w[15:12], w[1], w[2]};
        act = {lk_hit, lk_miss, lk_pfn, lk_re, lk_we, lk_for, lk_fow};
        check(act == exp, (k >= 0) ? "R5" : "R6", "lookup", 64'(act), 64'(exp));
        check(rb_pte == exp_rb, "R11", "readback", rb_pte, exp_rb);
        check(commit_err == exp_err, "R4", "commit_err", 64'(commit_err), 64'(exp_err));
    endtask

    task automatic update_model(input bit wen, input logic [3:0] sel, input logic [63:0] data,
                                input bit lkv, input bit lks, input logic [63:0] va);
        int s, k, r;
        logic [63:0] pw, tw;
        if (lkv) begin
            k = mfind(lks, va);
            exp_rb = (k < 0) ? '0 : ((mw[lks][k] & KEEP) | (64'(masn[lks][k]) << 57));
        end
        exp_err = 1'b0;
        if (wen) begin
            s = sel[3];
            case (sel[2:0])
                3'd0: mcur[s] = data[6:0];
                3'd1: begin mheld[s] = 1'b1; mstage[s] = data; end
                3'd2: begin
                    pw = s ? data : mstage[s];
                    tw = s ? mstage[s] : data;
                    if (!mheld[s] || pw[6:5] != 2'b00) begin
                        exp_err = 1'b1;
                    end else begin
                        r = mrr[s];
                        mv[s][r] = 1'b1;
                        mvpn[s][r] = tw[42:13];
                        mw[s][r] = s ? (pw & ~64'hF000) : pw;
                        masn[s][r] = mcur[s];
                        mrr[s] = (r + 1) % 16;
                        mheld[s] = 1'b0;
                    end
                end
                3'd3: for (int i = 0; i < 16; i++) mv[s][i] = 1'b0;
                3'd4: for (int i = 0; i < 16; i++) if (!mw[s][i][4]) mv[s][i] = 1'b0;
                3'd5: for (int i = 0; i < 16; i++)
                          if (mv[s][i] && mvpn[s][i] == data[42:13] &&
                              (mw[s][i][4] || masn[s][i] == mcur[s])) mv[s][i] = 1'b0;
                default: ;
            endcase
        end
    endtask

    // mode: 0 none, 1 hit+frame, 2 readback, 3 commit_err, 4 hit+write enables
    task automatic step(input bit wen, input logic [3:0] sel, input logic [63:0] data,
                        input bit lkv, input bit lks, input logic [63:0] va,
                        input int mode, input logic [63:0] xv, input bit xh, input string tag);
        @(negedge clk);
        wr_en = wen; wr_sel = sel; wr_data = data;
        lk_valid = lkv; lk_side = lks; lk_va = va;
        #1;
        compare_model();
        case (mode)
            1: check(lk_hit == xh && lk_pfn == xv[26:0], tag, "hit/frame",
                     {36'd0, lk_hit, lk_pfn}, {36'd0, xh, xv[26:0]});
            2: check(rb_pte == xv, tag, "rb_pte", rb_pte, xv);
            3: check(commit_err == xv[0], tag, "commit_err", 64'(commit_err), 64'(xv[0]));
            4: check(lk_hit && lk_we == xv[3:0], tag, "write enables",
                     {59'd0, lk_hit, lk_we}, {59'd0, 1'b1, xv[3:0]});
            default: ;
        endcase
        @(posedge clk);
        update_model(wen, sel, data, lkv, lks, va);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [63:0] data);
        step(1'b1, sel, data, 1'b0, 1'b0, '0, 0, '0, 1'b0, "");
    endtask

    task automatic look(input bit side, input logic [63:0] va, input bit xh,
                        input int pfn, input string tag);
        step(1'b0, '0, '0, 1'b1, side, va, 1, 64'(pfn), xh, tag);
    endtask

    task automatic idle_chk(input int mode, input logic [63:0] xv, input string tag);
        step(1'b0, '0, '0, 1'b0, 1'b0, '0, mode, xv, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = 64'h4000;
        #1;
        // reset state: R6 lookup outputs, R11 read-back, R4 error flag
        check(lk_miss && !lk_hit && lk_pfn == 0, "R6", "reset lookup", 64'(lk_hit), 64'd0);
        check(rb_pte == 0, "R11", "reset rb_pte", rb_pte, 64'd0);
        check(commit_err == 0, "R4", "reset commit_err", 64'(commit_err), 64'd0);
        lk_valid = 1'b0;
        rst_n = 1'b1;

        // R2 data-side staging
        wr(4'h0, 64'd5);
        wr(4'h1, mkpte(32'h123456, 4'hF, 4'h3, 1, 0, 0, 0));
        wr(4'h2, 64'h4000);
        look(0, 64'h4ABC, 1, 32'h123456, "R2");
        idle_chk(2, 64'h0A12_3456_0000_3F02, "R11");
        look(0, 64'h6000, 0, 0, "R6");
        idle_chk(2, 64'd0, "R11");

        // R4 rejections
        wr(4'h2, 64'h8000);
        idle_chk(3, 64'd1, "R4");
        look(0, 64'h8000, 0, 0, "R4");
        wr(4'h1, mkpte(32'h77, 1, 1, 0, 0, 1, 1));
        wr(4'h2, 64'h8000);
        idle_chk(3, 64'd1, "R4");
        look(0, 64'h8000, 0, 0, "R4");
        wr(4'h1, mkpte(32'h77, 1, 1, 0, 0, 1, 0));
        wr(4'h2, 64'h8000);
        idle_chk(3, 64'd0, "R4");
        look(0, 64'h8000, 1, 32'h77, "R2");
        wr(4'h2, 64'hA000);
        idle_chk(3, 64'd1, "R4");

        // R5 address-space qualification, global entry
        wr(4'h0, 64'd6);
        look(0, 64'h4000, 0, 0, "R5");
        look(0, 64'h8000, 1, 32'h77, "R5");

        // R3 instruction side, R12 isolation
        wr(4'h8, 64'd9);
        wr(4'h9, 64'hA000);
        wr(4'hA, mkpte(32'h55, 4'h1, 4'hF, 0, 0, 0, 0));
        look(1, 64'hA000, 1, 32'h55, "R3");
        step(1'b0, '0, '0, 1'b1, 1'b1, 64'hA000, 4, 64'd0, 1'b1, "R3");
        look(0, 64'hA000, 0, 0, "R12");
        look(1, 64'h8000, 0, 0, "R12");

        // R1 unused operation codes
        wr(4'h6, '1);
        wr(4'h7, '1);
        wr(4'hE, '1);
        idle_chk(3, 64'd0, "R1");
        look(0, 64'h8000, 1, 32'h77, "R1");
        look(1, 64'hA000, 1, 32'h55, "R1");

        // R9 invalidate non-global
        wr(4'h0, 64'd5);
        look(0, 64'h4000, 1, 32'h123456, "R9");
        wr(4'h4, 64'd0);
        look(0, 64'h4000, 0, 0, "R9");
        look(0, 64'h8000, 1, 32'h77, "R9");

        // R10 invalidate single
        wr(4'h1, mkpte(32'h11, 1, 1, 0, 0, 0, 0));
        wr(4'h2, 64'hC000);
        wr(4'h0, 64'd7);
        wr(4'h1, mkpte(32'h22, 1, 1, 0, 0, 0, 0));
        wr(4'h2, 64'hE000);
        wr(4'h5, 64'hC000);
        wr(4'h0, 64'd5);
        look(0, 64'hC000, 1, 32'h11, "R10");
        wr(4'h5, 64'hC000);
        look(0, 64'hC000, 0, 0, "R10");
        wr(4'h0, 64'd7);
        look(0, 64'hE000, 1, 32'h22, "R10");
        wr(4'h5, 64'h8000);
        look(0, 64'h8000, 0, 0, "R10");

        // R7 round-robin wrap over sixteen slots
        for (int k = 0; k < 16; k++) begin
            wr(4'h1, mkpte(32'h100 + k, 1, 0, 0, 0, 1, 0));
            wr(4'h2, 64'(32'h100 + k) << 13);
            if (k == 11) look(0, 64'hE000, 1, 32'h22, "R7");
        end
        look(0, 64'hE000, 0, 0, "R7");
        look(0, 64'h100 << 13, 1, 32'h100, "R7");
        look(0, 64'h10F << 13, 1, 32'h10F, "R7");

        // R8 invalidate all, data then instruction
        wr(4'h3, 64'd0);
        look(0, 64'h10F << 13, 0, 0, "R8");
        look(1, 64'hA000, 1, 32'h55, "R12");

        // R5 lowest-numbered match wins
        wr(4'h9, 64'h2000);
        wr(4'hA, mkpte(32'h31, 1, 0, 0, 0, 0, 0));
        wr(4'h9, 64'h2000);
        wr(4'hA, mkpte(32'h32, 1, 0, 0, 0, 0, 0));
        look(1, 64'h2000, 1, 32'h31, "R5");

        wr(4'hB, 64'd0);
        look(1, 64'hA000, 0, 0, "R8");
        look(1, 64'h2000, 0, 0, "R8");
        idle_chk(2, 64'd0, "R11");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule